// File: doc/BRIEF.md
# Lockable Seconds and Sub-Second Timekeeper

The block keeps device time as a 32-bit count of whole seconds and a 16-bit sub-second count. The sub-second count advances once per clock-enable tick, where one tick is 32 µs, and so it runs from 0 to 31249 within each second. The host can overwrite the seconds count, which also zeroes the sub-second count. It can do this only while the counter is unlocked. Command writes switch the counter between a locked state, which rejects loads, and an unlocked state, which accepts them. The counter comes out of reset unlocked.

An 8-bit offset register holds a correction in 500 µs steps. The block turns this correction into whole 32 µs ticks, rounding down. It adds the ticks to the reported time, with carry into seconds. The raw counters are not changed by the offset. Each time the seconds count advances because the sub-second count wrapped, the block raises a one-cycle heartbeat strobe.

Top module: `ts_timekeeper`

## Requirements
- R1: After reset, the raw seconds, raw sub-second, offset readback and heartbeat are all 0. The counter is unlocked, so the locked status is 0 and the unlocked status is 1.
- R2: With no accepted load, each cycle with `tick_en` high raises the sub-second count by one. A cycle without `tick_en` leaves both counts unchanged. The sub-second count never exceeds 31249.
- R3: A tick while the sub-second count is 31249 sets it to 0 and raises seconds by one on the same edge. Seconds wrap from 0xFFFFFFFF to 0.
- R4: When `load_valid` is high and the counter is unlocked, the next edge sets seconds to `load_sec` and the sub-second count to 0. An accepted load takes precedence over a tick in the same cycle.
- R5: A write on `cmd_wr` with `cmd_data` bit 7 set locks the counter. A write with bit 6 or bit 0 set, and bit 7 clear, unlocks it. When bit 7 and an unlock bit are both set, the lock wins. A write with none of these bits set leaves the state alone. The two status outputs are always complementary.
- R6: A write on `off_wr` stores `off_data` as the offset. The reported time equals the raw time plus floor(offset × 500 / 32) ticks. If that sum passes 31249, the reported sub-second count wraps and the reported seconds count is the raw seconds count plus one.
- R7: `heartbeat` is high for exactly the one cycle in which seconds shows a rollover increment. It stays low after loads.
- R8: While the counter is locked, `load_valid` has no effect. Seconds and sub-second counts follow only the tick rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per 32 µs of time |
| load_valid | input | 1 | Request to load seconds |
| load_sec | input | 32 | Seconds value to load |
| cmd_wr | input | 1 | Lock/unlock command strobe |
| cmd_data | input | 8 | Command byte: bit 7 lock, bit 6 unlock, bit 0 repeat-enable (also unlocks) |
| off_wr | input | 1 | Offset write strobe |
| off_data | input | 8 | Offset value in 500 µs steps |
| sec_raw | output | 32 | Raw seconds count |
| sub_raw | output | 16 | Raw sub-second count (32 µs units) |
| sec_out | output | 32 | Seconds with offset applied |
| sub_out | output | 16 | Sub-second count with offset applied |
| stat_locked | output | 1 | 1 while loads are rejected |
| stat_unlocked | output | 1 | 1 while loads are accepted |
| off_rd | output | 8 | Stored offset readback |
| heartbeat | output | 1 | One-cycle strobe on each seconds rollover |

## Verification
The bench drives the sub-second count across the 31249 boundary twice. One of these crossings starts from a loaded seconds value of 0xFFFFFFFF. A counter with the wrong wrap point, or one that forgets to carry into seconds, drifts from the model at that point, and so does a counter that strobes the heartbeat late.

A load is issued in the same cycle as a tick to show which of the two takes precedence. Loads are also issued while the counter is locked; a design that ignores the lock would show the loaded value. The lock and unlock bits are written together to check that the lock wins.

The largest offset, 3984 ticks, makes the reported time carry into seconds well before the raw rollover. A different rounding, or a missing carry, would show up as a wrong reported time throughout that window.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD   = 2'd0,
    CMD_LOCK   = 2'd1,
    CMD_UNLOCK = 2'd2
  } lock_cmd_e;

  // Lock has priority over either unlock source.
  function automatic lock_cmd_e decode_lock_cmd(logic lock_bit, logic unlock_bit, logic rep_bit);
    if (lock_bit)                return CMD_LOCK;
    else if (unlock_bit || rep_bit) return CMD_UNLOCK;
    else                         return CMD_HOLD;
  endfunction

  // Offset steps to whole ticks: off * num / 2^shift, rounded down.
  function automatic logic [31:0] offset_to_ticks(logic [31:0] off, logic [31:0] num, int shift);
    logic [31:0] prod;
    prod = off * num;
    return prod >> shift;
  endfunction

endpackage

// File: rtl/ts_lock_ctrl.sv
module ts_lock_ctrl #(
  parameter int CMD_W      = 8,
  parameter int LOCK_BIT   = 7,
  parameter int UNLOCK_BIT = 6,
  parameter int REP_BIT    = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             locked
);
  import ts_pkg::*;

  lock_cmd_e cmd;
  logic      locked_q;

  always_comb begin
    cmd = decode_lock_cmd(cmd_data[LOCK_BIT], cmd_data[UNLOCK_BIT], cmd_data[REP_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
    end else if (cmd_wr) begin
      case (cmd)
        CMD_LOCK:   locked_q <= 1'b1;
        CMD_UNLOCK: locked_q <= 1'b0;
        default:    locked_q <= locked_q;
      endcase
    end
  end

  assign locked = locked_q;
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int SEC_W   = 32,
  parameter int SUB_W   = 16,
  parameter int SUB_MAX = 31249
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_accept,
  input  logic [SEC_W-1:0] load_sec,
  output logic [SEC_W-1:0] sec_q,
  output logic [SUB_W-1:0] sub_q,
  output logic             roll_event,
  output logic             heartbeat
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_MAX);

  assign roll_event = tick && (sub_q == SUB_LAST) && !load_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q     <= '0;
      sub_q     <= '0;
      heartbeat <= 1'b0;
    end else begin
      heartbeat <= roll_event;
      if (load_accept) begin
        sec_q <= load_sec;
        sub_q <= '0;
      end else if (roll_event) begin
        sec_q <= sec_q + 1'b1;
        sub_q <= '0;
      end else if (tick) begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ts_offset_adder.sv
module ts_offset_adder #(
  parameter int SEC_W     = 32,
  parameter int SUB_W     = 16,
  parameter int SUB_MAX   = 31249,
  parameter int OFF_W     = 8,
  parameter int STEP_NUM  = 125,
  parameter int STEP_SHFT = 3
) (
  input  logic [SEC_W-1:0] sec_in,
  input  logic [SUB_W-1:0] sub_in,
  input  logic [OFF_W-1:0] off,
  output logic [SEC_W-1:0] sec_out,
  output logic [SUB_W-1:0] sub_out,
  output logic             carry
);
  import ts_pkg::*;

  localparam int SUM_W = SUB_W + 1;
  localparam logic [SUM_W-1:0] SUM_LAST = SUM_W'(SUB_MAX);
  localparam logic [SUM_W-1:0] SUM_SPAN = SUM_W'(SUB_MAX + 1);

  logic [31:0]      ticks32;
  logic [SUM_W-1:0] sum;

  // The largest offset converts to fewer ticks than one second, so one
  // conditional subtraction is enough.
  always_comb begin
    ticks32 = offset_to_ticks(32'(off), 32'(STEP_NUM), STEP_SHFT);
    sum     = {1'b0, sub_in} + SUM_W'(ticks32);
    carry   = (sum > SUM_LAST);
    if (carry) begin
      sub_out = SUB_W'(sum - SUM_SPAN);
      sec_out = sec_in + 1'b1;
    end else begin
      sub_out = SUB_W'(sum);
      sec_out = sec_in;
    end
  end
endmodule

// File: rtl/ts_timekeeper.sv
module ts_timekeeper #(
  parameter int SEC_W     = 32,
  parameter int SUB_W     = 16,
  parameter int SUB_MAX   = 31249,
  parameter int OFF_W     = 8,
  parameter int CMD_W     = 8,
  parameter int STEP_NUM  = 125,
  parameter int STEP_SHFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_valid,
  input  logic [SEC_W-1:0] load_sec,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             off_wr,
  input  logic [OFF_W-1:0] off_data,
  output logic [SEC_W-1:0] sec_raw,
  output logic [SUB_W-1:0] sub_raw,
  output logic [SEC_W-1:0] sec_out,
  output logic [SUB_W-1:0] sub_out,
  output logic             stat_locked,
  output logic             stat_unlocked,
  output logic [OFF_W-1:0] off_rd,
  output logic             heartbeat
);
  logic             locked;
  logic             load_accept;
  logic             roll_event;
  logic             out_carry;
  logic [OFF_W-1:0] off_q;

  assign load_accept = load_valid && !locked;

  ts_lock_ctrl #(
    .CMD_W(CMD_W), .LOCK_BIT(7), .UNLOCK_BIT(6), .REP_BIT(0)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .locked(locked)
  );

  ts_counter #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .SUB_MAX(SUB_MAX)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .load_accept(load_accept),
    .load_sec(load_sec), .sec_q(sec_raw), .sub_q(sub_raw),
    .roll_event(roll_event), .heartbeat(heartbeat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_wr) off_q <= off_data;
  end

  ts_offset_adder #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .SUB_MAX(SUB_MAX), .OFF_W(OFF_W),
    .STEP_NUM(STEP_NUM), .STEP_SHFT(STEP_SHFT)
  ) u_off (
    .sec_in(sec_raw), .sub_in(sub_raw), .off(off_q),
    .sec_out(sec_out), .sub_out(sub_out), .carry(out_carry)
  );

  assign off_rd        = off_q;
  assign stat_locked   = locked;
  assign stat_unlocked = !locked;
endmodule

// File: rtl/ts_timekeeper_chk.sv
module ts_timekeeper_chk #(
  parameter int SEC_W   = 32,
  parameter int SUB_W   = 16,
  parameter int SUB_MAX = 31249
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             load_valid,
  input logic [SEC_W-1:0] load_sec,
  input logic [SEC_W-1:0] sec_raw,
  input logic [SUB_W-1:0] sub_raw,
  input logic [SUB_W-1:0] sub_out,
  input logic             stat_locked,
  input logic             stat_unlocked,
  input logic             heartbeat,
  input logic             load_accept,
  input logic             roll_event
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_MAX);

  assert_sub_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sub_raw <= SUB_LAST);

  assert_roll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && sub_raw == SUB_LAST && !load_accept) |=> (sub_raw == '0 && heartbeat));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && !stat_locked) |=> (sec_raw == $past(load_sec) && sub_raw == '0));

  assert_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({stat_locked, stat_unlocked}) == 1);

  assert_out_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sub_out <= SUB_LAST);

  assert_hb_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    heartbeat |-> (sec_raw == $past(sec_raw) + 1'b1));

  assert_hb_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    roll_event |=> !roll_event);

  assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_locked && load_valid && !tick_en) |=> ($stable(sec_raw) && $stable(sub_raw)));
endmodule

bind ts_timekeeper ts_timekeeper_chk #(
  .SEC_W(SEC_W), .SUB_W(SUB_W), .SUB_MAX(SUB_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_valid(load_valid),
  .load_sec(load_sec), .sec_raw(sec_raw), .sub_raw(sub_raw), .sub_out(sub_out),
  .stat_locked(stat_locked), .stat_unlocked(stat_unlocked), .heartbeat(heartbeat),
  .load_accept(load_accept), .roll_event(roll_event)
);

// File: tb/ts_timekeeper_test.sv
`timescale 1ns/1ps
module ts_timekeeper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, load_valid = 1'b0, cmd_wr = 1'b0, off_wr = 1'b0;
  logic [31:0] load_sec = '0;
  logic [7:0]  cmd_data = '0, off_data = '0;
  logic [31:0] sec_raw, sec_out;
  logic [15:0] sub_raw, sub_out;
  logic        stat_locked, stat_unlocked, heartbeat;
  logic [7:0]  off_rd;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  ts_timekeeper uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_valid(load_valid),
    .load_sec(load_sec), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .off_wr(off_wr),
    .off_data(off_data), .sec_raw(sec_raw), .sub_raw(sub_raw), .sec_out(sec_out),
    .sub_out(sub_out), .stat_locked(stat_locked), .stat_unlocked(stat_unlocked),
    .off_rd(off_rd), .heartbeat(heartbeat)
  );

  // Behavioural reference model
  longint m_sec = 0;
  int     m_sub = 0;
  bit     m_lock = 0;
  int     m_off = 0;
  bit     m_hb = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_sec = 0; m_sub = 0; m_lock = 0; m_off = 0; m_hb = 0;
    end else begin
      m_hb = 0;
      if (load_valid && !m_lock) begin
        m_sec = load_sec; m_sub = 0;
      end else if (tick_en) begin
        if (m_sub == 31249) begin
          m_sub = 0; m_sec = (m_sec + 1) % 64'h1_0000_0000; m_hb = 1;
        end else m_sub = m_sub + 1;
      end
      if (cmd_wr) begin
        if (cmd_data[7]) m_lock = 1;
        else if (cmd_data[6] || cmd_data[0]) m_lock = 0;
      end
      if (off_wr) m_off = off_data;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int     t;
      longint es;
      t  = m_sub + (m_off * 500) / 32;
      es = m_sec;
      if (t >= 31250) begin t = t - 31250; es = (es + 1) % 64'h1_0000_0000; end
      check("R3 seconds", sec_raw, m_sec);
      check("R2 subsecond", sub_raw, m_sub);
      check("R5 locked", stat_locked, m_lock);
      check("R5 unlocked", stat_unlocked, !m_lock);
      check("R6 offset readback", off_rd, m_off);
      check("R6 reported seconds", sec_out, es);
      check("R6 reported subsecond", sub_out, t);
      check("R7 heartbeat", heartbeat, m_hb);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
    end
  endtask

  task automatic clear_strobes();
    load_valid = 0; cmd_wr = 0; off_wr = 0; tick_en = 0;
  endtask

  task automatic do_cmd(logic [7:0] v);
    cmd_wr = 1; cmd_data = v; step(1); cmd_wr = 0; step(1);
  endtask

  task automatic do_load(logic [31:0] v, logic with_tick);
    load_valid = 1; load_sec = v; tick_en = with_tick; step(1);
    load_valid = 0; tick_en = 0; step(1);
  endtask

  task automatic ticks(int n);
    tick_en = 1; step(n); tick_en = 0; step(1);
  endtask

  initial begin
    step(3);
    // R1: reset values
    check("R1 seconds", sec_raw, 0);
    check("R1 subsecond", sub_raw, 0);
    check("R1 unlocked", stat_unlocked, 1);
    check("R1 locked", stat_locked, 0);
    check("R1 offset", off_rd, 0);
    check("R1 heartbeat", heartbeat, 0);
    rst_n = 1;
    step(4);                               // R2: no tick, no change
    for (int i = 0; i < 20; i++) begin     // R2: sparse ticks
      tick_en = (i % 2 == 0); step(1);
    end
    clear_strobes(); step(1);
    do_load(32'd100, 1'b1);                // R4: load beats tick
    ticks(7);
    do_cmd(8'h80);                         // R5: lock
    do_load(32'd555, 1'b0);                // R8: ignored
    do_load(32'd556, 1'b1);                // R8: ignored, tick counts
    do_cmd(8'hC0);                         // R5: lock wins
    do_load(32'd557, 1'b0);
    do_cmd(8'h00);                         // R5: hold
    do_cmd(8'h40);                         // R5: unlock
    do_cmd(8'h80);
    do_cmd(8'h01);                         // R5: repeat bit unlocks
    off_wr = 1; off_data = 8'd255; step(1); off_wr = 0;   // R6
    do_load(32'hFFFF_FFFF, 1'b0);          // R3: wrap through max seconds
    ticks(31260);
    off_wr = 1; off_data = 8'd7; step(1); off_wr = 0;     // R6: rounding
    do_load(32'd41, 1'b0);
    ticks(31300);                          // R7: heartbeat at 42
    off_wr = 1; off_data = 8'd0; step(1); off_wr = 0;
    ticks(10);
    step(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(20 * 190000);
    misses++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule